// File: doc/BRIEF.md
# HDLC Receive Deframer

This block takes a bit-serial HDLC line and turns it back into bytes. A bit is taken only on a system clock cycle where the receive tick is high and the receive enable is high. Each bit taken is shifted into an 8-bit window. The block looks for the flag pattern 0x7E in that window after every bit. Once a flag has been seen, the bits that follow are frame content until the next flag. Zeros inserted by the sender after runs of five ones are removed. The remaining bits are packed into bytes, least significant bit first.

Each byte is presented with a first-byte marker. When a frame closes, one end record reports the frame's length in bytes and a good/bad verdict. The verdict combines four things: the frame-check residue compared against a configurable constant, byte alignment, a minimum length, and whether an abort was seen. Downstream logic uses the verdict to keep or drop the bytes it has already received.

A run of seven ones is taken as an abort. The block then reports the open frame as bad and waits for a new flag. Header interpretation and buffering belong to the consumer.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: After a synchronous reset, `byte_valid` and `end_valid` are low and stay low until frame content and flags arrive.
- R2: A line bit is taken only on a clock where `rx_tick` and `rx_en` are both high. Line values on any other clock have no effect on the byte stream or the end records.
- R3: A flag is the pattern 0x7E (0,1,1,1,1,1,1,0 on the line) found in the 8-bit window of the most recent bits taken. Bits between two flags are delivered as bytes on `byte_data`, first line bit in bit 0. Flag bits are never delivered. Two flags with nothing between them produce no byte and no end record.
- R4: A zero that follows five consecutive content ones is removed and is not part of any byte.
- R5: The first byte of each frame has `byte_sof` high, and every later byte of that frame has it low.
- R6: The frame check is computed over all content bytes, including the two check bytes. It uses the reflected form of x^16+x^12+x^5+1 (constant 0x8408), preset to 0xFFFF, with bits taken LSB first. A frame is good only if the final register equals `check_const`. When the sender appends the complement of the check register, low byte first, the residue is 0xF0B8.
- R7: `end_len` reports the number of content bytes of the frame, including the check bytes.
- R8: A frame whose closing flag arrives with a partial byte pending (content bits not a multiple of 8) is reported bad.
- R9: A frame with fewer than 2 content bytes is reported bad.
- R10: Seven consecutive ones form an abort. If a frame with content is open, one end record with `end_good` low is issued. No further content is accepted until the next flag. An abort with no open content issues nothing.
- R11: Outputs are registered. A byte, and an end record, appears in the clock cycle right after the sampling edge of the bit that completes it, and stays valid for one cycle.
- R12: A single flag both closes one frame and opens the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_tick | input | 1 | One-cycle pulse marking a receive clock rising edge |
| rx_en | input | 1 | Receive enable; a bit is taken only when high with `rx_tick` |
| rx_data | input | 1 | Serial line data |
| check_const | input | 16 | Residue value a good frame must leave in the check register |
| byte_valid | output | 1 | One-cycle strobe for `byte_data` |
| byte_data | output | 8 | Recovered content byte |
| byte_sof | output | 1 | High with the first byte of a frame |
| end_valid | output | 1 | One-cycle strobe for the end record |
| end_good | output | 1 | Frame passed residue, alignment, length and abort checks |
| end_len | output | LEN_W | Frame length in bytes |

## Verification
A content byte is due one clock after the sampling edge of the bit that pushes its last bit out of the 8-bit window. That bit is eight taken bits after the byte's own last bit. An end record is due one clock after the sampling edge of the closing flag's last bit. The bench reads that exact falling edge for the end-record latency check. It collects bytes and end records on falling edges, and compares a frame's results only after a few idle clocks following its closing flag. Because of this, the irregular gaps and disabled cycles between bits never shift the moment a result is read.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int FLAG_W = 8;
  localparam logic [FLAG_W-1:0] FLAG_PAT = 8'h7E;
  localparam int BYTE_W = 8;
  localparam int FCS_W = 16;
  localparam logic [FCS_W-1:0] FCS_POLY_R = 16'h8408;
  localparam logic [FCS_W-1:0] FCS_PRESET = 16'hFFFF;

  function automatic logic [FCS_W-1:0] fcs_step(input logic [FCS_W-1:0] c, input logic b);
    return (c >> 1) ^ (((c[0] ^ b) == 1'b1) ? FCS_POLY_R : '0);
  endfunction
endpackage

// File: rtl/hdlc_flag_window.sv
module hdlc_flag_window
  import hdlc_rx_pkg::*;
#(
  parameter int ABORT_RUN = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic samp,
  input  logic bit_in,
  output logic flag_hit,
  output logic abort_hit,
  output logic out_valid,
  output logic out_bit
);
  localparam int CNT_W = $clog2(FLAG_W + 1);
  localparam int RUN_W = $clog2(ABORT_RUN + 1);

  logic [FLAG_W-1:0] win;
  logic [FLAG_W-1:0] win_nxt;
  logic [CNT_W-1:0]  fill;
  logic [RUN_W-1:0]  run;

  assign win_nxt   = {bit_in, win[FLAG_W-1:1]};
  assign flag_hit  = samp && (win_nxt == FLAG_PAT);
  assign abort_hit = samp && bit_in && (run == RUN_W'(ABORT_RUN - 1));
  assign out_valid = samp && (fill == CNT_W'(FLAG_W));
  assign out_bit   = win[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      win  <= '0;
      fill <= '0;
      run  <= '0;
    end else if (samp) begin
      win <= win_nxt;
      if (!bit_in)                        run <= '0;
      else if (run != RUN_W'(ABORT_RUN))  run <= run + 1'b1;
      if (flag_hit || abort_hit)          fill <= '0;
      else if (fill != CNT_W'(FLAG_W))    fill <= fill + 1'b1;
    end
  end

  // R3
  flag_restart_chk: assert property (@(posedge clk) disable iff (rst)
    flag_hit |=> (fill == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !samp |=> $stable(win));
endmodule

// File: rtl/hdlc_zero_destuff.sv
module hdlc_zero_destuff #(
  parameter int STUFF_RUN = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_bit,
  input  logic clear,
  output logic data_valid,
  output logic data_bit
);
  localparam int ONES_W = $clog2(STUFF_RUN + 1);

  logic [ONES_W-1:0] ones;
  logic stuffed;

  assign stuffed    = in_valid && !in_bit && (ones == ONES_W'(STUFF_RUN));
  assign data_valid = in_valid && !stuffed;
  assign data_bit   = in_bit;

  always_ff @(posedge clk) begin
    if (rst || clear)                         ones <= '0;
    else if (in_valid) begin
      if (!in_bit)                            ones <= '0;
      else if (ones != ONES_W'(STUFF_RUN))    ones <= ones + 1'b1;
    end
  end

  // R4
  stuff_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_bit) |=> (ones == '0));
endmodule

// File: rtl/hdlc_fcs16.sv
module hdlc_fcs16
  import hdlc_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             en,
  input  logic             bit_in,
  output logic [FCS_W-1:0] crc_nxt
);
  logic [FCS_W-1:0] crc;

  assign crc_nxt = en ? fcs_step(crc, bit_in) : crc;

  always_ff @(posedge clk) begin
    if (rst || clear) crc <= FCS_PRESET;
    else              crc <= crc_nxt;
  end

  // R6
  fcs_preset_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (crc == FCS_PRESET));
endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int STUFF_RUN = 5,
  parameter int ABORT_RUN = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_tick,
  input  logic             rx_en,
  input  logic             rx_data,
  input  logic [15:0]      check_const,
  output logic             byte_valid,
  output logic [7:0]       byte_data,
  output logic             byte_sof,
  output logic             end_valid,
  output logic             end_good,
  output logic [LEN_W-1:0] end_len
);
  localparam int BC_W    = $clog2(BYTE_W);
  localparam int MIN_LEN = FCS_W / BYTE_W;

  logic samp, flag_hit, abort_hit, out_valid, out_bit;
  logic data_valid, data_bit, restart;
  logic [FCS_W-1:0] crc_nxt;

  logic              in_frame, sof_pend;
  logic [BC_W-1:0]   bit_cnt;
  logic [BYTE_W-2:0] sh;
  logic [LEN_W-1:0]  byte_cnt;

  logic              dv, byte_done, len_inc, has_body, term, good_c;
  logic [BC_W-1:0]   bits_after;
  logic [LEN_W-1:0]  len_after;
  logic [BYTE_W-1:0] assembled;

  assign samp    = rx_tick && rx_en;
  assign restart = flag_hit || abort_hit;

  hdlc_flag_window #(.ABORT_RUN(ABORT_RUN)) win_i (
    .clk(clk), .rst(rst), .samp(samp), .bit_in(rx_data),
    .flag_hit(flag_hit), .abort_hit(abort_hit),
    .out_valid(out_valid), .out_bit(out_bit)
  );

  hdlc_zero_destuff #(.STUFF_RUN(STUFF_RUN)) dst_i (
    .clk(clk), .rst(rst), .in_valid(out_valid), .in_bit(out_bit),
    .clear(restart), .data_valid(data_valid), .data_bit(data_bit)
  );

  hdlc_fcs16 fcs_i (
    .clk(clk), .rst(rst), .clear(restart), .en(dv),
    .bit_in(data_bit), .crc_nxt(crc_nxt)
  );

  always_comb begin
    dv         = data_valid && in_frame;
    byte_done  = dv && (bit_cnt == BC_W'(BYTE_W - 1));
    assembled  = {data_bit, sh};
    bits_after = bit_cnt + BC_W'(dv);
    len_inc    = byte_done && (byte_cnt != '1);
    len_after  = byte_cnt + LEN_W'(len_inc);
    has_body   = (len_after != '0) || (bits_after != '0);
    term       = restart && in_frame && has_body;
    good_c     = flag_hit && (bits_after == '0) &&
                 (len_after >= LEN_W'(MIN_LEN)) && (crc_nxt == check_const);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_valid <= 1'b0;
      byte_data  <= '0;
      byte_sof   <= 1'b0;
      end_valid  <= 1'b0;
      end_good   <= 1'b0;
      end_len    <= '0;
      in_frame   <= 1'b0;
      sof_pend   <= 1'b0;
      bit_cnt    <= '0;
      sh         <= '0;
      byte_cnt   <= '0;
    end else begin
      byte_valid <= byte_done;
      byte_sof   <= byte_done && sof_pend;
      if (byte_done) byte_data <= assembled;
      end_valid  <= term;
      end_good   <= term && good_c;
      if (term) end_len <= len_after;

      if (flag_hit) begin
        in_frame <= 1'b1;
        sof_pend <= 1'b1;
        bit_cnt  <= '0;
        byte_cnt <= '0;
      end else if (abort_hit) begin
        in_frame <= 1'b0;
        sof_pend <= 1'b0;
        bit_cnt  <= '0;
        byte_cnt <= '0;
      end else if (dv) begin
        sh      <= assembled[BYTE_W-1:1];
        bit_cnt <= bits_after;
        if (byte_done) begin
          byte_cnt <= len_after;
          sof_pend <= 1'b0;
        end
      end
    end
  end

  // R11
  end_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    end_valid |=> !end_valid);

  // R11
  byte_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid);

  // R9
  min_len_chk: assert property (@(posedge clk) disable iff (rst)
    (end_valid && end_good) |-> (end_len >= LEN_W'(MIN_LEN)));

  // R10
  abort_close_chk: assert property (@(posedge clk) disable iff (rst)
    abort_hit |=> !in_frame);
endmodule

// File: tb/hdlc_rx_deframer_tb_top.sv
module hdlc_rx_deframer_tb_top;
  typedef logic [7:0] u8_t;
  typedef u8_t u8q_t[$];

  logic clk = 1'b0, rst = 1'b1;
  logic rx_tick = 1'b0, rx_en = 1'b0, rx_data = 1'b0;
  logic [15:0] check_const = 16'hF0B8;
  logic byte_valid, byte_sof, end_valid, end_good;
  logic [7:0] byte_data;
  logic [15:0] end_len;

  hdlc_rx_deframer dut_i (
    .clk(clk), .rst(rst), .rx_tick(rx_tick), .rx_en(rx_en), .rx_data(rx_data),
    .check_const(check_const), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_sof(byte_sof), .end_valid(end_valid), .end_good(end_good), .end_len(end_len)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  int tx_ones = 0;
  bit noisy = 0;
  logic last_end;

  u8_t got_b[$];
  bit  got_s[$];
  int  got_end_n = 0;
  bit  got_good;
  int  got_len;

  always @(negedge clk) begin
    if (!rst) begin
      if (byte_valid) begin got_b.push_back(byte_data); got_s.push_back(byte_sof); end
      if (end_valid) begin got_end_n++; got_good = end_good; got_len = int'(end_len); end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input u8_t b);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) r = (r >> 1) ^ (((r[0] ^ b[i]) == 1'b1) ? 16'h8408 : 16'h0000);
    return r;
  endfunction

  function automatic logic [15:0] residue(input u8q_t t);
    logic [15:0] r = 16'hFFFF;
    foreach (t[i]) r = crc_byte(r, t[i]);
    return r;
  endfunction

  function automatic u8q_t add_fcs(input u8q_t p);
    u8q_t t = p;
    logic [15:0] f = ~residue(p);
    t.push_back(f[7:0]);
    t.push_back(f[15:8]);
    return t;
  endfunction

  task automatic send_bit(input bit b);
    int gaps = noisy ? 6 : $urandom_range(0, 2);
    for (int g = 0; g < gaps; g++) begin
      @(negedge clk);
      rx_tick = $urandom_range(0, 1);
      rx_en   = rx_tick ? 1'b0 : 1'($urandom_range(0, 1));
      rx_data = noisy ? 1'b1 : 1'($urandom_range(0, 1));
    end
    @(negedge clk);
    rx_tick = 1'b1; rx_en = 1'b1; rx_data = b;
    @(negedge clk);
    rx_tick = 1'b0; rx_en = 1'($urandom_range(0, 1)); rx_data = 1'($urandom_range(0, 1));
    last_end = end_valid;
  endtask

  task automatic send_flag();
    send_bit(0);
    for (int i = 0; i < 6; i++) send_bit(1);
    send_bit(0);
    tx_ones = 0;
  endtask

  task automatic send_data_bit(input bit b);
    send_bit(b);
    if (b) begin
      tx_ones++;
      if (tx_ones == 5) begin send_bit(0); tx_ones = 0; end
    end else tx_ones = 0;
  endtask

  task automatic send_byte(input u8_t v);
    for (int i = 0; i < 8; i++) send_data_bit(v[i]);
  endtask

  task automatic clear_mon();
    got_b.delete(); got_s.delete(); got_end_n = 0;
  endtask

  task automatic run_frame(input u8q_t tx, input int extra, input int lead, input string req);
    bit exp_good;
    bit bytes_ok = 1, sof_ok = 1;
    clear_mon();
    for (int i = 0; i < lead; i++) send_flag();
    foreach (tx[i]) send_byte(tx[i]);
    for (int i = 0; i < extra; i++) send_data_bit(0);
    send_flag();
    chk(last_end === 1'b1, "R11", "end record one clock after closing flag", int'(last_end), 1);
    repeat (3) @(negedge clk);
    exp_good = (extra == 0) && (tx.size() >= 2) && (residue(tx) == check_const);
    chk(got_end_n == 1, "R3", "end record count", got_end_n, 1);
    chk(got_good == exp_good, req, "end_good", int'(got_good), int'(exp_good));
    chk(got_len == tx.size(), "R7", "end_len", got_len, tx.size());
    chk(got_b.size() == tx.size(), "R3", "byte count", got_b.size(), tx.size());
    foreach (tx[i]) if (i < got_b.size() && got_b[i] !== tx[i]) bytes_ok = 0;
    foreach (got_s[i]) if (got_s[i] !== (i == 0)) sof_ok = 0;
    chk(bytes_ok, "R4", "byte contents after destuffing", int'(bytes_ok), 1);
    chk(sof_ok, "R5", "start-of-frame marking", int'(sof_ok), 1);
  endtask

  task automatic run_abort(input u8q_t tx, input int lead);
    clear_mon();
    for (int i = 0; i < lead; i++) send_flag();
    foreach (tx[i]) send_byte(tx[i]);
    for (int i = 0; i < 8; i++) send_bit(1);
    repeat (3) @(negedge clk);
    chk(got_end_n == 1, "R10", "abort end record count", got_end_n, 1);
    chk(got_good == 1'b0, "R10", "abort end_good", int'(got_good), 0);
  endtask

  function automatic u8q_t rand_payload(input int n);
    u8q_t p;
    for (int i = 0; i < n; i++) begin
      case ($urandom_range(0, 3))
        0: p.push_back(8'hFF);
        1: p.push_back(8'h7E);
        default: p.push_back(u8_t'($urandom_range(0, 255)));
      endcase
    end
    return p;
  endfunction

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    u8q_t p, t;
    bit prev_abort;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(byte_valid === 1'b0, "R1", "byte_valid after reset", int'(byte_valid), 0);
    chk(end_valid === 1'b0, "R1", "end_valid after reset", int'(end_valid), 0);

    // R10 hunt: ones with no open frame give no record
    clear_mon();
    for (int i = 0; i < 12; i++) send_bit(1);
    repeat (2) @(negedge clk);
    chk(got_end_n == 0, "R10", "abort without frame emits nothing", got_end_n, 0);

    // R4 directed stuffing content, R3 idle flags before
    p = '{8'hFF, 8'h7E, 8'h3F, 8'hF8, 8'h1F};
    run_frame(add_fcs(p), 0, 3, "R6");

    // R12 shared flag between frames
    run_frame(add_fcs(rand_payload(4)), 0, 0, "R12");

    // R2 disabled cycles carrying ones are ignored
    noisy = 1;
    run_frame(add_fcs(rand_payload(3)), 0, 1, "R2");
    noisy = 0;

    // R9 short frames
    p = '{8'hA5};
    run_frame(p, 0, 1, "R9");
    p.delete();
    run_frame(p, 3, 1, "R8");

    // R10 abort then a clean frame
    run_abort(rand_payload(3), 1);
    run_frame(add_fcs(rand_payload(2)), 0, 1, "R10");

    // R6 alternative constant: standard frame now bad, matched residue now good
    check_const = 16'h1D0F;
    run_frame(add_fcs(rand_payload(3)), 0, 1, "R6");
    t = rand_payload(4);
    t.push_back(8'h00); t.push_back(8'h00);
    check_const = residue(t);
    run_frame(t, 0, 1, "R6");
    check_const = 16'hF0B8;

    // random mix
    prev_abort = 0;
    for (int k = 0; k < 25; k++) begin
      int mode = $urandom_range(0, 5);
      int lead = prev_abort ? 1 : $urandom_range(0, 2);
      p = rand_payload($urandom_range(1, 10));
      prev_abort = 0;
      case (mode)
        3: begin t = add_fcs(p); t[0] = t[0] ^ 8'h10; run_frame(t, 0, lead, "R6"); end
        4: run_frame(add_fcs(p), $urandom_range(1, 7), lead, "R8");
        5: begin run_abort(p, lead < 1 ? 1 : lead); prev_abort = 1; end
        default: run_frame(add_fcs(p), 0, lead, "R6");
      endcase
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule